// File: doc/BRIEF.md
# Power-Fail Interrupt Sequencer

This block sits between the supply-monitor inputs and a processor's interrupt system. It filters an AC-line-good signal, tracks a DC power-on signal, and raises a single interrupt request at a fixed vector for two events: the line failing and power coming back. Software reads a direction flag to learn which event occurred. A control flip-flop, which software arms, gates each request. Raising a request disarms the flip-flop, so a second event cannot nest inside the handler until software arms it again.

After a failure is detected, the block holds its power-on status output high for a programmable warning window. Transfers already in progress can complete, and software can save its state during this window. The output then drops. If the line recovers inside the window, the block reports power-up at once and the output never drops. If the line recovers after the output has dropped, power-up is reported only after the DC input has stayed high for a programmable number of cycles. While a request is pending, the block drives an inhibit output that masks all lower-priority interrupts.

Software reaches the block through a strobed operation port. `op_code` 2'b00 arms the control flip-flop, 2'b01 disarms it, 2'b10 tests the direction flag, and 2'b11 acknowledges (clears) the pending request.

Top module: `pwr_fail_seq`

## Requirements
- R1: After reset, `irq_o` is 0, `pwr_on_o` is 0, the control flip-flop is disarmed and the direction flag is 0. Once the filtered line is good and `dc_on_i` has stayed high for `STABLE_CYC` cycles, `pwr_on_o` rises. No request is raised because the block is disarmed.
- R2: A low pulse on `line_ok_i` shorter than `FILT_CYC` cycles has no effect. `irq_o` stays 0 and `pwr_on_o` stays 1.
- R3: A request is raised only while the control flip-flop is armed, and raising it disarms the flip-flop. After op 2'b01, or after an event with no re-arm, later events raise no request.
- R4: The direction flag is 0 after a failure and 1 after a restore, and every transition updates it. Op 2'b10 returns it on `test_flag_o`, with `test_vld_o` high, one cycle later.
- R5: After a failure is detected, `pwr_on_o` stays 1 for `HOLD_CYC` cycles and then drops to 0.
- R6: If the filtered line returns while `pwr_on_o` is still 1 and the block is armed, a power-up request is raised at once and `pwr_on_o` does not drop.
- R7: After `pwr_on_o` has dropped, a restore is reported only when the line is good and `dc_on_i` has been high for `STABLE_CYC` consecutive cycles. At that point `pwr_on_o` rises and the direction flag is set to 1.
- R8: A pending request stays raised until op 2'b11 clears it. `inhibit_o` is high exactly while a request is pending. `vec_o` always carries the value `VECTOR` (default 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_ok_i | input | 1 | Raw AC-line-good sense, asynchronous |
| dc_on_i | input | 1 | DC supply power-on sense |
| op_valid_i | input | 1 | Operation strobe, one cycle per operation |
| op_code_i | input | 2 | 00 arm, 01 disarm, 10 test flag, 11 acknowledge |
| irq_o | output | 1 | Pending power-fail interrupt request |
| vec_o | output | VEC_W | Fixed interrupt vector |
| inhibit_o | output | 1 | Masks lower-priority interrupts |
| pwr_on_o | output | 1 | Power-on status to the system |
| test_vld_o | output | 1 | Test-flag result valid |
| test_flag_o | output | 1 | Direction flag: 0 means down, 1 means up |

## Verification
The assertions assume that every operation strobe lasts exactly one cycle and that `op_code_i` is steady while it is valid. They also assume that `line_ok_i` changes slowly compared with the clock, except for deliberate glitches. The bench drives all inputs on the falling clock edge and issues operations one at a time. It holds each line level for many more cycles than `FILT_CYC`, except in the glitch scenario. It lowers `dc_on_i` only once `pwr_on_o` has dropped, which matches a real supply that decays after the warning window.

// File: rtl/pwr_fail_pkg.sv
package pwr_fail_pkg;
  typedef enum logic [1:0] {
    OP_ARM   = 2'b00,
    OP_DISARM = 2'b01,
    OP_TEST  = 2'b10,
    OP_ACK   = 2'b11
  } pf_op_e;

  typedef enum logic [1:0] {
    ST_DOWN = 2'b00,
    ST_UP   = 2'b01,
    ST_WARN = 2'b10
  } pf_state_e;
endpackage

// File: rtl/pf_glitch_filter.sv
module pf_glitch_filter #(
  parameter int FILT_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
      filt_o <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == filt_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_CYC - 1)) begin
        filt_o <= sync_q[1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pf_stable_counter.sv
module pf_stable_counter #(
  parameter int STABLE_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic stable_o
);
  localparam int CW = $clog2(STABLE_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !level_i) cnt_q <= '0;
    else if (cnt_q != CW'(STABLE_CYC)) cnt_q <= cnt_q + 1'b1;
  end

  assign stable_o = (cnt_q == CW'(STABLE_CYC));
endmodule

// File: rtl/pf_sequencer.sv
module pf_sequencer
  import pwr_fail_pkg::*;
#(
  parameter int HOLD_CYC = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_f_i,
  input  logic       dc_stable_i,
  input  logic       op_valid_i,
  input  logic [1:0] op_code_i,
  output logic       irq_o,
  output logic       dir_o,
  output logic       armed_o,
  output logic       pwr_on_o,
  output logic       test_vld_o,
  output logic       test_flag_o
);
  localparam int HW = $clog2(HOLD_CYC + 1);

  pf_state_e     state_q;
  logic [HW-1:0] hold_q;
  logic          ev_dn, ev_up, event_any;
  pf_op_e        op;

  assign op = pf_op_e'(op_code_i);

  always_comb begin
    ev_dn = 1'b0;
    ev_up = 1'b0;
    unique case (state_q)
      ST_UP:   ev_dn = !line_f_i;
      ST_WARN: ev_up = line_f_i;
      ST_DOWN: ev_up = line_f_i && dc_stable_i;
      default: ;
    endcase
  end
  assign event_any = ev_dn || ev_up;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_DOWN;
      hold_q  <= '0;
    end else begin
      unique case (state_q)
        ST_UP: if (ev_dn) begin
          state_q <= ST_WARN;
          hold_q  <= '0;
        end
        ST_WARN: begin
          if (ev_up) state_q <= ST_UP;
          else if (hold_q == HW'(HOLD_CYC - 1)) state_q <= ST_DOWN;
          else hold_q <= hold_q + 1'b1;
        end
        ST_DOWN: if (ev_up) state_q <= ST_UP;
        default: state_q <= ST_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o       <= 1'b0;
      dir_o       <= 1'b0;
      armed_o     <= 1'b0;
      test_vld_o  <= 1'b0;
      test_flag_o <= 1'b0;
    end else begin
      test_vld_o  <= op_valid_i && (op == OP_TEST);
      test_flag_o <= op_valid_i && (op == OP_TEST) && dir_o;
      if (op_valid_i) begin
        case (op)
          OP_ARM:    armed_o <= 1'b1;
          OP_DISARM: armed_o <= 1'b0;
          OP_ACK:    irq_o   <= 1'b0;
          default:   ;
        endcase
      end
      if (event_any) begin
        dir_o <= ev_up;
        if (armed_o) begin
          irq_o   <= 1'b1;
          armed_o <= 1'b0;
        end
      end
    end
  end

  assign pwr_on_o = (state_q != ST_DOWN);
endmodule

// File: rtl/pwr_fail_seq.sv
module pwr_fail_seq #(
  parameter int FILT_CYC   = 8,
  parameter int HOLD_CYC   = 100,
  parameter int STABLE_CYC = 20,
  parameter int VEC_W      = 6,
  parameter int VECTOR     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_ok_i,
  input  logic             dc_on_i,
  input  logic             op_valid_i,
  input  logic [1:0]       op_code_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             inhibit_o,
  output logic             pwr_on_o,
  output logic             test_vld_o,
  output logic             test_flag_o
);
  logic line_f;
  logic dc_stable;
  logic dir;
  logic armed;

  pf_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(line_ok_i), .filt_o(line_f)
  );

  pf_stable_counter #(.STABLE_CYC(STABLE_CYC)) u_dc (
    .clk(clk), .rst_n(rst_n), .level_i(dc_on_i), .stable_o(dc_stable)
  );

  pf_sequencer #(.HOLD_CYC(HOLD_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .line_f_i(line_f), .dc_stable_i(dc_stable),
    .op_valid_i(op_valid_i), .op_code_i(op_code_i),
    .irq_o(irq_o), .dir_o(dir), .armed_o(armed), .pwr_on_o(pwr_on_o),
    .test_vld_o(test_vld_o), .test_flag_o(test_flag_o)
  );

  assign vec_o     = VEC_W'(VECTOR);
  assign inhibit_o = irq_o;
endmodule

// File: rtl/pwr_fail_seq_chk.sv
module pwr_fail_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_o,
  input logic       pwr_on_o,
  input logic       op_valid_i,
  input logic [1:0] op_code_i,
  input logic       line_f,
  input logic       armed
);
  AST_IRQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(armed)); // R3
  AST_IRQ_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> !armed); // R3
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !(op_valid_i && op_code_i == 2'b11)) |=> irq_o); // R8
  AST_DROP_AFTER_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_on_o) |-> !$past(line_f)); // R5
  AST_IRQ_WHILE_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> pwr_on_o); // R6
endmodule

bind pwr_fail_seq pwr_fail_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .pwr_on_o(pwr_on_o),
  .op_valid_i(op_valid_i), .op_code_i(op_code_i),
  .line_f(line_f), .armed(armed)
);

// File: tb/pwr_fail_seq_bench.sv
module pwr_fail_seq_bench;
  localparam int FILT = 8;
  localparam int HOLD = 100;
  localparam int STAB = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_ok_i = 1'b0;
  logic       dc_on_i = 1'b0;
  logic       op_valid_i = 1'b0;
  logic [1:0] op_code_i = 2'b00;
  logic       irq_o, inhibit_o, pwr_on_o, test_vld_o, test_flag_o;
  logic [5:0] vec_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwr_fail_seq #(.FILT_CYC(FILT), .HOLD_CYC(HOLD), .STABLE_CYC(STAB),
                 .VEC_W(6), .VECTOR(4)) u_pwr_fail_seq (
    .clk(clk), .rst_n(rst_n), .line_ok_i(line_ok_i), .dc_on_i(dc_on_i),
    .op_valid_i(op_valid_i), .op_code_i(op_code_i), .irq_o(irq_o),
    .vec_o(vec_o), .inhibit_o(inhibit_o), .pwr_on_o(pwr_on_o),
    .test_vld_o(test_vld_o), .test_flag_o(test_flag_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_op(input logic [1:0] code);
    @(negedge clk);
    op_valid_i = 1'b1;
    op_code_i  = code;
    @(negedge clk);
    op_valid_i = 1'b0;
  endtask

  task automatic read_flag(input string req, input int exp);
    do_op(2'b10);
    check({req, " test_vld"}, test_vld_o, 1);
    check({req, " flag"}, test_flag_o, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 irq after reset", irq_o, 0);
    check("R1 pwr_on after reset", pwr_on_o, 0);
    read_flag("R1", 0);
    line_ok_i = 1'b1;
    dc_on_i   = 1'b1;
    wait_cyc(FILT + STAB + 6);
    check("R1 pwr_on rises", pwr_on_o, 1);
    check("R1 R3 no irq when disarmed", irq_o, 0);
    read_flag("R4 flag after start", 1);
  endtask

  task automatic t_glitch;
    do_op(2'b00);
    @(negedge clk);
    line_ok_i = 1'b0;
    wait_cyc(FILT - 2);
    line_ok_i = 1'b1;
    wait_cyc(20);
    check("R2 glitch irq", irq_o, 0);
    check("R2 glitch pwr_on", pwr_on_o, 1);
  endtask

  task automatic t_full_cycle;
    // armed from t_glitch
    line_ok_i = 1'b0;
    wait_cyc(FILT + 5);
    check("R8 irq on fail", irq_o, 1);
    check("R8 inhibit", inhibit_o, 1);
    check("R8 vector", vec_o, 4);
    read_flag("R4 down flag", 0);
    do_op(2'b11);
    check("R8 ack clears irq", irq_o, 0);
    check("R8 inhibit clears", inhibit_o, 0);
    wait_cyc(HOLD - 30);
    check("R5 pwr_on held", pwr_on_o, 1);
    wait_cyc(30);
    dc_on_i = 1'b0;
    check("R5 pwr_on dropped", pwr_on_o, 0);
    do_op(2'b00);
    line_ok_i = 1'b1;
    wait_cyc(FILT + 8);
    check("R7 no restore without dc", pwr_on_o, 0);
    check("R7 no irq without dc", irq_o, 0);
    dc_on_i = 1'b1;
    wait_cyc(STAB - 5);
    check("R7 dc not yet stable", pwr_on_o, 0);
    check("R7 dc not yet stable irq", irq_o, 0);
    wait_cyc(8);
    check("R7 restore pwr_on", pwr_on_o, 1);
    check("R7 restore irq", irq_o, 1);
    read_flag("R4 up flag", 1);
    do_op(2'b11);
  endtask

  task automatic t_early_restore;
    do_op(2'b00);
    line_ok_i = 1'b0;
    wait_cyc(FILT + 5);
    check("R6 down irq", irq_o, 1);
    do_op(2'b11);
    do_op(2'b00);
    wait_cyc(30);
    line_ok_i = 1'b1;
    wait_cyc(FILT + 5);
    check("R6 up irq at once", irq_o, 1);
    check("R6 pwr_on kept", pwr_on_o, 1);
    read_flag("R6 up flag", 1);
    do_op(2'b11);
    wait_cyc(HOLD);
    check("R6 pwr_on still on", pwr_on_o, 1);
  endtask

  task automatic t_disarm;
    do_op(2'b00);
    do_op(2'b01);
    line_ok_i = 1'b0;
    wait_cyc(FILT + 5);
    check("R3 disarmed no irq", irq_o, 0);
    read_flag("R4 flag tracks fail", 0);
    line_ok_i = 1'b1;
    wait_cyc(FILT + 5);
    check("R3 disarmed no up irq", irq_o, 0);
    read_flag("R4 flag tracks restore", 1);
  endtask

  task automatic t_no_rearm;
    do_op(2'b00);
    line_ok_i = 1'b0;
    wait_cyc(FILT + 5);
    check("R3 armed irq", irq_o, 1);
    do_op(2'b11);
    wait_cyc(10);
    line_ok_i = 1'b1;
    wait_cyc(FILT + 5);
    check("R3 not rearmed no irq", irq_o, 0);
    check("R3 pwr_on stays", pwr_on_o, 1);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_glitch();
    t_full_cycle();
    t_early_restore();
    t_disarm();
    t_no_rearm();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule